// File: doc/BRIEF.md
# Self-Timed Byte-Write Controller for a Parallel Non-Volatile Memory

This block is the control and storage logic of a byte-wide non-volatile memory that a host uses like a static RAM. The host drives active-low chip-enable, output-enable and write-enable strobes, an 11-bit address and an 8-bit data bus. Reads are immediate. A write is a single low pulse on write-enable. The block keeps the address and data it saw during that pulse, so the host buses are free again once the pulse ends. The block then runs an erase step followed by a program step, each timed internally.

While the sequence runs, the block pulls its ready/busy line low. The line is modelled as an open-drain pull-down enable, so several devices can share one wired line. The host can also poll for completion. While busy, any read returns the inverse of the written byte's top bit. Once ready, a read of the written location returns the new byte.

A chip-clear request, sampled when a write pulse is accepted, erases the whole array through the same busy sequence. A write pulse is discarded in any of these cases: it is too short, the supply monitor reports low supply, the inhibit input is high, or a sequence is already running.

Top module: `byte_nvm_ctrl`

## Requirements
- R1: A read (ceN=0, oeN=0, weN=1) while ready drives the byte stored at addr on dataOut with dataOe=1. Without that strobe pattern, dataOe=0 and dataOut=0.
- R2: A write is accepted on the first clock where weN is sampled high after a low run of at least PULSE_MIN samples with ceN=0 and oeN=1. The address and data of the last low sample are used, and later changes on addr and dataIn have no effect on that write.
- R3: From the clock after acceptance, busyDrvLow=1 for exactly (LONG_WRITE ? 1000 : 200) * CYC_PER_US cycles. The first half (rounded down) is the erase step and the rest is the program step.
- R4: After a byte write completes, the target byte holds the written data, whatever it held before: erase sets it to 0xFF, then program loads the data.
- R5: While busyDrvLow=1, a read of any address returns the inverted bit 7 of the latched data on bit 7 and zeros on bits 6..0.
- R6: After busyDrvLow returns to 0, a read of the written address returns the written byte.
- R7: If chipClr=1 on the acceptance cycle, every byte reads 0xFF once the sequence ends, and busy lasts as long as a byte write.
- R8: A write pulse is ignored when supplyOk=0 or wrInhibit=1 on the acceptance cycle: no busy, and no byte changes.
- R9: A write-enable low run shorter than PULSE_MIN samples is ignored: no busy, and no byte changes.
- R10: A write pulse during busy is ignored. The running sequence is neither extended nor altered, and the attempted byte is unchanged.
- R11: After reset, busyDrvLow=0 and every byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| supplyOk | input | 1 | Supply-level detect, 1 = supply good |
| wrInhibit | input | 1 | Write inhibit, 1 = block writes |
| chipClr | input | 1 | Turns an accepted write into a whole-array clear |
| addr | input | 11 | Byte address |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data |
| dataOe | output | 1 | Read data valid / bus drive enable |
| busyDrvLow | output | 1 | Open-drain ready/busy pull-down enable, 1 = busy |

## Verification
A table of writes is applied to the main write path. The entries use both values of data bit 7, so a polling read that returns a stuck or uninverted bit is caught. Pulse lengths of exactly PULSE_MIN and longer show where the acceptance boundary lies. An overwrite of 0x0F by 0xF0 shows that the erase step runs before the program step. The address and data buses are scrambled right after every write pulse, which exposes sampling on the wrong edge. Directed cases cover a pulse one sample too short, low supply, inhibit, a write during busy, and a full-array clear checked at every address.

// File: rtl/byte_nvm_pkg.sv
package byte_nvm_pkg;

  typedef struct packed {
    logic capture;
    logic eraseByte;
    logic eraseAll;
    logic progByte;
  } nvm_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ERASE = 2'd1,
    ST_PROG  = 2'd2
  } nvm_state_t;

endpackage

// File: rtl/byte_nvm_control.sv
module byte_nvm_control
  import byte_nvm_pkg::*;
#(
  parameter int PULSE_MIN  = 3,
  parameter int CYC_PER_US = 125,
  parameter bit LONG_WRITE = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        oeN,
  input  logic        weN,
  input  logic        supplyOk,
  input  logic        wrInhibit,
  input  logic        chipClr,
  output nvm_strobe_t stb,
  output logic        busy
);

  localparam int TOTAL_CYC = (LONG_WRITE ? 1000 : 200) * CYC_PER_US;
  localparam int ERASE_CYC = TOTAL_CYC / 2;
  localparam int PROG_CYC  = TOTAL_CYC - ERASE_CYC;
  localparam int TIMER_W   = $clog2(TOTAL_CYC + 1);
  localparam int CNT_W     = $clog2(PULSE_MIN + 1);

  nvm_state_t         state;
  logic [TIMER_W-1:0] timer;
  logic [CNT_W-1:0]   lowCnt;
  logic               wasLow;
  logic               clrMode;
  logic               wrLow;
  logic               pulseOk;
  logic               accept;
  logic               timerDone;

  // Write strobe window: chip selected, output disabled, write enable low.
  assign wrLow     = !ceN && oeN && !weN;
  assign pulseOk   = (lowCnt >= CNT_W'(PULSE_MIN));
  assign accept    = wasLow && weN && pulseOk && supplyOk && !wrInhibit
                     && (state == ST_IDLE);
  assign timerDone = (timer == '0);

  // Pulse-width filter: saturating count of consecutive low samples.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
      wasLow <= 1'b0;
    end else begin
      wasLow <= wrLow;
      if (!wrLow) begin
        lowCnt <= '0;
      end else if (!pulseOk) begin
        lowCnt <= lowCnt + 1'b1;
      end
    end
  end

  // Sequencer: erase step, then program step.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      timer   <= '0;
      clrMode <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_ERASE;
            timer   <= TIMER_W'(ERASE_CYC - 1);
            clrMode <= chipClr;
          end
        end
        ST_ERASE: begin
          if (timerDone) begin
            state <= ST_PROG;
            timer <= TIMER_W'(PROG_CYC - 1);
          end else begin
            timer <= timer - 1'b1;
          end
        end
        ST_PROG: begin
          if (timerDone) begin
            state <= ST_IDLE;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.capture   = wrLow && (state == ST_IDLE);
    stb.eraseByte = (state == ST_ERASE) && timerDone && !clrMode;
    stb.eraseAll  = (state == ST_ERASE) && timerDone && clrMode;
    stb.progByte  = (state == ST_PROG) && timerDone && !clrMode;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/byte_nvm_datapath.sv
module byte_nvm_datapath
  import byte_nvm_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  nvm_strobe_t       stb,
  input  logic              busy,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [ADDR_W-1:0] latAddr,
  output logic [DATA_W-1:0] latData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              readSel;

  // Address/data latches follow the bus during the write pulse only.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latAddr <= '0;
      latData <= '0;
    end else if (stb.capture) begin
      latAddr <= addr;
      latData <= dataIn;
    end
  end

  // Cell array: resets to the erased state.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (stb.eraseAll) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (stb.eraseByte) begin
      mem[latAddr] <= '1;
    end else if (stb.progByte) begin
      mem[latAddr] <= latData;
    end
  end

  assign readSel = !ceN && !oeN && weN;

  always_comb begin
    dataOe  = readSel;
    dataOut = '0;
    if (readSel) begin
      if (busy) begin
        dataOut[DATA_W-1] = ~latData[DATA_W-1];
      end else begin
        dataOut = mem[addr];
      end
    end
  end

endmodule

// File: rtl/byte_nvm_ctrl.sv
module byte_nvm_ctrl
  import byte_nvm_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PULSE_MIN  = 3,
  parameter int CYC_PER_US = 125,
  parameter bit LONG_WRITE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              supplyOk,
  input  logic              wrInhibit,
  input  logic              chipClr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              busyDrvLow
);

  nvm_strobe_t       ctrlStb;
  logic              busy;
  logic [ADDR_W-1:0] latAddr;
  logic [DATA_W-1:0] latData;

  byte_nvm_control #(
    .PULSE_MIN (PULSE_MIN),
    .CYC_PER_US(CYC_PER_US),
    .LONG_WRITE(LONG_WRITE)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .ceN      (ceN),
    .oeN      (oeN),
    .weN      (weN),
    .supplyOk (supplyOk),
    .wrInhibit(wrInhibit),
    .chipClr  (chipClr),
    .stb      (ctrlStb),
    .busy     (busy)
  );

  byte_nvm_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (ctrlStb),
    .busy   (busy),
    .ceN    (ceN),
    .oeN    (oeN),
    .weN    (weN),
    .addr   (addr),
    .dataIn (dataIn),
    .dataOut(dataOut),
    .dataOe (dataOe),
    .latAddr(latAddr),
    .latData(latData)
  );

  assign busyDrvLow = busy;

endmodule

// File: rtl/byte_nvm_checker.sv
module byte_nvm_checker #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              supplyOk,
  input logic              wrInhibit,
  input logic              busyDrvLow,
  input logic              dataOe,
  input logic [DATA_W-1:0] dataOut,
  input logic [ADDR_W-1:0] latAddr,
  input logic [DATA_W-1:0] latData,
  input logic              eraseByte,
  input logic              eraseAll,
  input logic              progByte
);

  p_no_drive_r1: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (dataOut == '0));

  p_guard_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyDrvLow) |-> ($past(supplyOk) && !$past(wrInhibit)));

  p_latch_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busyDrvLow && $past(busyDrvLow)) |-> ($stable(latAddr) && $stable(latData)));

  p_poll_bit7_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busyDrvLow && dataOe) |-> (dataOut[DATA_W-1] == !latData[DATA_W-1]));

  p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({eraseByte, eraseAll, progByte}));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busyDrvLow |-> !(eraseByte || eraseAll || progByte));

endmodule

bind byte_nvm_ctrl byte_nvm_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .supplyOk  (supplyOk),
  .wrInhibit (wrInhibit),
  .busyDrvLow(busyDrvLow),
  .dataOe    (dataOe),
  .dataOut   (dataOut),
  .latAddr   (latAddr),
  .latData   (latData),
  .eraseByte (ctrlStb.eraseByte),
  .eraseAll  (ctrlStb.eraseAll),
  .progByte  (ctrlStb.progByte)
);

// File: tb/byte_nvm_ctrl_tb_top.sv
`timescale 1ns/1ps
module byte_nvm_ctrl_tb_top;

  localparam int ADDR_W    = 11;
  localparam int DATA_W    = 8;
  localparam int PULSE_MIN = 3;
  localparam int TOTAL     = 200;   // LONG_WRITE=0, CYC_PER_US=1
  localparam int DEPTH     = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic              supplyOk = 1'b1, wrInhibit = 1'b0, chipClr = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] dataIn = '0;
  logic [DATA_W-1:0] dataOut;
  logic              dataOe;
  logic              busyDrvLow;

  int checkCnt = 0;
  int failCnt  = 0;
  int busyCnt  = 0;

  always #4 clk = ~clk;   // 125 MHz

  byte_nvm_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_MIN(PULSE_MIN),
    .CYC_PER_US(1), .LONG_WRITE(1'b0)
  ) dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .supplyOk(supplyOk), .wrInhibit(wrInhibit), .chipClr(chipClr),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .busyDrvLow(busyDrvLow)
  );

  always @(negedge clk) if (busyDrvLow) busyCnt++;

  // Vector: address, data, low-pulse length in samples.
  localparam logic [26:0] VEC [6] = '{
    {11'd0,    8'hA5, 8'd3},
    {11'd2047, 8'h3C, 8'd5},
    {11'd17,   8'h0F, 8'd3},
    {11'd17,   8'hF0, 8'd4},
    {11'd1024, 8'h00, 8'd9},
    {11'd555,  8'hFF, 8'd3}
  };

  task automatic check(input string req, input int act, input int exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic readByte(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d,
                          output logic oe);
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b0; weN = 1'b1; addr = a;
    #1;
    d = dataOut; oe = dataOe;
    ceN = 1'b1; oeN = 1'b1;
  endtask

  // Drives a write pulse of lowLen samples, then scrambles the buses.
  task automatic writePulse(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            input int lowLen, input logic clr);
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b1; weN = 1'b0; addr = a; dataIn = d; chipClr = clr;
    repeat (lowLen) @(negedge clk);
    weN = 1'b1; addr = ~a; dataIn = ~d;
    @(negedge clk);
    ceN = 1'b1; chipClr = 1'b0;
  endtask

  task automatic waitReady();
    while (busyDrvLow) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] rd;
    logic              oe;
    int                bad;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11 reset state
    @(negedge clk);
    check("R11 busy after reset", busyDrvLow, 0);
    readByte(11'd5, rd, oe);
    check("R11 erased byte after reset", rd, 8'hFF);
    check("R1 read drives bus", oe, 1);
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b1; weN = 1'b1; #1;
    check("R1 no drive when oeN high", {dataOe, dataOut}, 0);
    ceN = 1'b1;

    // Table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < 6; i++) begin
      logic [ADDR_W-1:0] va;
      logic [DATA_W-1:0] vd;
      int                vl;
      va = VEC[i][26:16]; vd = VEC[i][15:8]; vl = int'(VEC[i][7:0]);
      busyCnt = 0;
      writePulse(va, vd, vl, 1'b0);
      check("R2 write accepted", busyDrvLow, 1);
      readByte(~va, rd, oe);
      check("R5 polling read", rd, {~vd[7], 7'b0});
      waitReady();
      check("R3 busy length", busyCnt, TOTAL);
      readByte(va, rd, oe);
      check("R6 R4 readback after write", rd, vd);
    end

    // R9 pulse one sample short
    writePulse(11'd100, 8'h12, PULSE_MIN - 1, 1'b0);
    check("R9 short pulse no busy", busyDrvLow, 0);
    readByte(11'd100, rd, oe);
    check("R9 short pulse byte unchanged", rd, 8'hFF);

    // R8 low supply, then inhibit
    supplyOk = 1'b0;
    writePulse(11'd101, 8'h34, 4, 1'b0);
    check("R8 low supply no busy", busyDrvLow, 0);
    supplyOk = 1'b1;
    readByte(11'd101, rd, oe);
    check("R8 low supply byte unchanged", rd, 8'hFF);
    wrInhibit = 1'b1;
    writePulse(11'd102, 8'h56, 4, 1'b0);
    check("R8 inhibit no busy", busyDrvLow, 0);
    wrInhibit = 1'b0;
    readByte(11'd102, rd, oe);
    check("R8 inhibit byte unchanged", rd, 8'hFF);

    // R10 write during busy
    busyCnt = 0;
    writePulse(11'd200, 8'h55, 4, 1'b0);
    writePulse(11'd300, 8'hE6, 4, 1'b0);
    readByte(11'd7, rd, oe);
    check("R10 poll shows first write", rd, {1'b1, 7'b0});
    waitReady();
    check("R10 busy not extended", busyCnt, TOTAL);
    readByte(11'd300, rd, oe);
    check("R10 ignored byte unchanged", rd, 8'hFF);
    readByte(11'd200, rd, oe);
    check("R10 running write completes", rd, 8'h55);

    // R7 chip clear
    busyCnt = 0;
    writePulse(11'd9, 8'h11, 4, 1'b1);
    check("R7 clear busy", busyDrvLow, 1);
    waitReady();
    check("R7 clear busy length", busyCnt, TOTAL);
    bad = 0;
    for (int a = 0; a < DEPTH; a++) begin
      readByte(ADDR_W'(a), rd, oe);
      if (rd !== 8'hFF) bad++;
    end
    check("R7 all bytes erased", bad, 0);

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule